// File: doc/BRIEF.md
# Interrupt Source Pending/Queued State Engine

This block keeps a two-bit state for each of a set of interrupt sources. The high bit (P, value 2'b10) means the source has been forwarded downstream and is waiting for an end-of-interrupt. The low bit (Q, value 2'b01) means another trigger arrived while P was set. The block coalesces triggers so that a source is owed to the downstream router at most once at any time. Triggers come from hardware lines (edge or level, chosen per source) or from stores to a per-source trigger page. Loads at fixed offsets in a per-source management page read the state, overwrite it, or perform an end-of-interrupt. Each load atomically returns the state as it was before the access.

Each source owns 2^PAGE_SHIFT bytes at offset `src << PAGE_SHIFT`. PAGE_SHIFT may be 12, 13, 16 or 17. With 13 or 17 the page is split: the lower half is the trigger page and the upper half (address bit PAGE_SHIFT-1 set) is the management page. With 12 or 16 a single page serves both purposes. Notifications leave on a valid/ready stream that carries the source number. `notif_valid` and `notif_src` stay stable until `notif_ready` is seen high at a clock edge. While the stream is stalled, new notifications are recorded internally, one bit per source, so none is lost. When several are owed, the lowest source number goes first.

Top module: `pq_source_engine`

## Requirements
- R1: After reset every source reads state 2'b00 and `notif_valid` is low.
- R2: A trigger moves 00 to 10 and emits a notification. It moves 10 to 11 without one, leaves 11 unchanged, and is dropped in state 01 (off).
- R3: A management load with page-offset bits [11:10]=00 performs end-of-interrupt and returns the old state. The new state is 10 with a fresh notification if Q was set, and 00 otherwise.
- R4: A management load with page-offset bits [11:10]=10 (offset 0x800) returns the state and leaves it unchanged. A load on the trigger page in split mode behaves the same way.
- R5: Management loads at 0xC00, 0xD00, 0xE00 and 0xF00 set the state to 00, 01, 10 and 11 respectively, return the old state, and never emit a notification.
- R6: When STORE_EOI_EN is 1, a store at management offset 0x400 performs the R3 end-of-interrupt without a response.
- R7: In split mode any store to the trigger page is a trigger, and a store elsewhere on the management page (other than 0x400) has no effect.
- R8: A rising edge on the hardware line of an edge source is one trigger; holding the line high triggers nothing more.
- R9: For a level source (LEVEL_MASK bit set), an end-of-interrupt while the line is still high re-triggers the source at once. With the line low, the source simply returns to 00.
- R10: `notif_valid`/`notif_src` hold while `notif_ready` is low. Owed notifications are kept per source and issued lowest number first.
- R11: Every load gives `rsp_valid` one cycle later, with the old P/Q state in `rsp_data[1:0]` and zeros above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | NUM_SRC | Hardware interrupt lines, one per source |
| reg_req | input | 1 | Register access strobe, always accepted |
| reg_wr | input | 1 | 1 = store, 0 = load |
| reg_addr | input | $clog2(NUM_SRC)+PAGE_SHIFT | Byte address within the source pages |
| rsp_valid | output | 1 | Load response valid, one cycle after the load |
| rsp_data | output | RSP_W | Old P/Q state, zero-extended |
| notif_valid | output | 1 | Notification available |
| notif_ready | input | 1 | Downstream accepts the notification |
| notif_src | output | $clog2(NUM_SRC) | Source number of the notification |

## Verification
A corrupted P/Q state is visible at the ports on the next management load, because every load returns the old state one cycle after it is issued. A read at offset 0x800 therefore exposes any stray transition immediately. A wrong trigger or end-of-interrupt decision shows as a missing or extra notification. It appears on the stream two clock edges after the access or line edge when the stream is idle. A lost or reordered owed bit surfaces as a wrong source number on a later handshake.

// File: rtl/pq_src_pkg.sv
package pq_src_pkg;

  typedef logic [1:0] pq_t;

  localparam pq_t PQ_IDLE   = 2'b00;
  localparam pq_t PQ_OFF    = 2'b01;
  localparam pq_t PQ_PEND   = 2'b10;
  localparam pq_t PQ_QUEUED = 2'b11;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_TRIG,
    OP_EOI,
    OP_GET,
    OP_SET
  } pq_op_e;

  typedef struct packed {
    pq_t  nxt;
    logic fire;
  } pq_step_t;

  // Coalescing trigger: only an idle source produces a notification.
  function automatic pq_step_t pq_on_trigger(pq_t cur);
    pq_step_t r;
    r.nxt  = cur;
    r.fire = 1'b0;
    if (cur == PQ_IDLE) begin
      r.nxt  = PQ_PEND;
      r.fire = 1'b1;
    end else if (cur == PQ_PEND) begin
      r.nxt = PQ_QUEUED;
    end
    return r;
  endfunction

  // End-of-interrupt: P cleared; a recorded Q is replayed as a new notification.
  function automatic pq_step_t pq_on_eoi(pq_t cur);
    pq_step_t r;
    if (cur[0]) begin
      r.nxt  = PQ_PEND;
      r.fire = 1'b1;
    end else begin
      r.nxt  = PQ_IDLE;
      r.fire = 1'b0;
    end
    return r;
  endfunction

endpackage

// File: rtl/pq_addr_decode.sv
module pq_addr_decode
  import pq_src_pkg::*;
#(
  parameter int NUM_SRC      = 8,
  parameter int PAGE_SHIFT   = 13,
  parameter bit STORE_EOI_EN = 1'b1,
  localparam int SRC_W  = $clog2(NUM_SRC),
  localparam int ADDR_W = SRC_W + PAGE_SHIFT
) (
  input  logic              req,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  output pq_op_e            op,
  output pq_t               set_val,
  output logic [SRC_W-1:0]  src,
  output logic              src_ok,
  output logic              is_load
);

  localparam bit SPLIT = (PAGE_SHIFT == 13) || (PAGE_SHIFT == 17);

  logic       on_mgmt;
  logic [3:0] sel;
  logic       unused_addr_bits;

  assign src              = addr[ADDR_W-1:PAGE_SHIFT];
  assign src_ok           = ({1'b0, src} < (SRC_W+1)'(NUM_SRC));
  assign sel              = addr[11:8];
  assign set_val          = sel[1:0];
  assign is_load          = req && !wr;
  assign unused_addr_bits = ^addr;

  generate
    if (SPLIT) begin : g_split
      assign on_mgmt = addr[PAGE_SHIFT-1];
    end else begin : g_single
      assign on_mgmt = 1'b1;
    end
  endgenerate

  always_comb begin
    op = OP_NONE;
    if (req) begin
      if (wr) begin
        if (SPLIT && !on_mgmt)                            op = OP_TRIG;
        else if (sel[3:2] == 2'b01 && STORE_EOI_EN)       op = OP_EOI;
        else if (!SPLIT)                                  op = OP_TRIG;
        else                                              op = OP_NONE;
      end else begin
        if (SPLIT && !on_mgmt) begin
          op = OP_GET;
        end else begin
          unique case (sel[3:2])
            2'b00:   op = OP_EOI;
            2'b11:   op = OP_SET;
            default: op = OP_GET;
          endcase
        end
      end
    end
  end

endmodule

// File: rtl/pq_state_cell.sv
module pq_state_cell
  import pq_src_pkg::*;
#(
  parameter bit IS_LEVEL = 1'b0
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   irq,
  input  pq_op_e op,
  input  pq_t    set_val,
  output pq_t    state,
  output logic   fire
);

  pq_t      state_q;
  logic     irq_q;       // line sampled; for a level source this is its asserted bit
  logic     line_rise;
  logic     retrig;
  pq_step_t step_a;
  pq_step_t step_b;
  pq_t      mid;

  assign line_rise = irq && !irq_q;
  assign retrig    = line_rise || (IS_LEVEL && irq && op == OP_EOI);

  always_comb begin
    step_a.nxt  = state_q;
    step_a.fire = 1'b0;
    unique case (op)
      OP_TRIG: step_a = pq_on_trigger(state_q);
      OP_EOI:  step_a = pq_on_eoi(state_q);
      OP_SET:  step_a.nxt = set_val;
      default: ;
    endcase
    mid    = step_a.nxt;
    step_b = pq_on_trigger(mid);
    if (!retrig) begin
      step_b.nxt  = mid;
      step_b.fire = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= PQ_IDLE;
      irq_q   <= 1'b0;
    end else begin
      state_q <= step_b.nxt;
      irq_q   <= irq;
    end
  end

  assign state = state_q;
  assign fire  = step_a.fire || step_b.fire;

  // R2
  off_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PQ_OFF && (op == OP_NONE || op == OP_TRIG || op == OP_GET))
      |=> (state_q == PQ_OFF));

  // R3
  eoi_requeue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PQ_QUEUED && op == OP_EOI && !irq_q && !irq)
      |=> (state_q == PQ_PEND));

endmodule

// File: rtl/pq_notify_arb.sv
module pq_notify_arb #(
  parameter int NUM_SRC = 8,
  localparam int SRC_W = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] set_req,
  output logic               valid,
  input  logic               ready,
  output logic [SRC_W-1:0]   src
);

  logic [NUM_SRC-1:0] owed_q;
  logic [NUM_SRC-1:0] clr_vec;
  logic [SRC_W-1:0]   pick;
  logic               pick_ok;
  logic               slot_free;
  logic               valid_q;
  logic [SRC_W-1:0]   src_q;

  always_comb begin
    pick    = '0;
    pick_ok = 1'b0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (owed_q[i]) begin
        pick    = SRC_W'(i);
        pick_ok = 1'b1;
      end
    end
  end

  assign slot_free = !valid_q || ready;
  assign clr_vec   = (slot_free && pick_ok) ? (NUM_SRC'(1) << pick) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      owed_q  <= '0;
      valid_q <= 1'b0;
      src_q   <= '0;
    end else begin
      owed_q <= (owed_q & ~clr_vec) | set_req;
      if (slot_free) begin
        valid_q <= pick_ok;
        src_q   <= pick;
      end
    end
  end

  assign valid = valid_q;
  assign src   = src_q;

  // R10
  notif_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !ready) |=> (valid_q && $stable(src_q)));

  // R10
  notif_src_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |-> ({1'b0, src_q} < (SRC_W+1)'(NUM_SRC)));

endmodule

// File: rtl/pq_source_engine.sv
module pq_source_engine
  import pq_src_pkg::*;
#(
  parameter int               NUM_SRC      = 8,
  parameter int               PAGE_SHIFT   = 13,
  parameter bit               STORE_EOI_EN = 1'b1,
  parameter logic [NUM_SRC-1:0] LEVEL_MASK = {1'b1, {(NUM_SRC-1){1'b0}}},
  parameter int               RSP_W        = 64,
  localparam int SRC_W  = $clog2(NUM_SRC),
  localparam int ADDR_W = SRC_W + PAGE_SHIFT
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_in,
  input  logic               reg_req,
  input  logic               reg_wr,
  input  logic [ADDR_W-1:0]  reg_addr,
  output logic               rsp_valid,
  output logic [RSP_W-1:0]   rsp_data,
  output logic               notif_valid,
  input  logic               notif_ready,
  output logic [SRC_W-1:0]   notif_src
);

  pq_op_e                  dec_op;
  pq_t                     dec_set;
  logic [SRC_W-1:0]        dec_src;
  logic                    dec_ok;
  logic                    dec_load;
  logic [NUM_SRC-1:0][1:0] state_vec;
  logic [NUM_SRC-1:0]      fire_vec;
  pq_t                     old_pq;
  logic                    rsp_valid_q;
  logic [RSP_W-1:0]        rsp_data_q;

  pq_addr_decode #(
    .NUM_SRC      (NUM_SRC),
    .PAGE_SHIFT   (PAGE_SHIFT),
    .STORE_EOI_EN (STORE_EOI_EN)
  ) u_decode (
    .req     (reg_req),
    .wr      (reg_wr),
    .addr    (reg_addr),
    .op      (dec_op),
    .set_val (dec_set),
    .src     (dec_src),
    .src_ok  (dec_ok),
    .is_load (dec_load)
  );

  generate
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      pq_op_e cell_op;
      pq_t    cell_state;
      assign cell_op      = (dec_ok && dec_src == SRC_W'(i)) ? dec_op : OP_NONE;
      assign state_vec[i] = cell_state;

      pq_state_cell #(
        .IS_LEVEL (LEVEL_MASK[i])
      ) u_cell (
        .clk     (clk),
        .rst_n   (rst_n),
        .irq     (irq_in[i]),
        .op      (cell_op),
        .set_val (dec_set),
        .state   (cell_state),
        .fire    (fire_vec[i])
      );
    end
  endgenerate

  pq_notify_arb #(
    .NUM_SRC (NUM_SRC)
  ) u_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_req (fire_vec),
    .valid   (notif_valid),
    .ready   (notif_ready),
    .src     (notif_src)
  );

  assign old_pq = dec_ok ? state_vec[dec_src] : PQ_IDLE;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
    end else begin
      rsp_valid_q <= dec_load;
      rsp_data_q  <= {{(RSP_W-2){1'b0}}, old_pq};
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_data  = rsp_data_q;

  // R11
  rsp_after_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_req && !reg_wr) |=> rsp_valid);

  // R11
  no_rsp_on_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_req && reg_wr) |=> !rsp_valid);

endmodule

// File: tb/pq_source_engine_bench.sv
module pq_source_engine_bench;

  localparam int N  = 8;
  localparam int SH = 13;
  localparam int SW = 3;
  localparam int AW = SW + SH;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  irq_in = '0;
  logic          reg_req = 1'b0;
  logic          reg_wr = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic          rsp_valid;
  logic [63:0]   rsp_data;
  logic          notif_valid;
  logic          notif_ready = 1'b0;
  logic [SW-1:0] notif_src;

  int  n_chk = 0;
  int  n_fail = 0;
  bit  done = 1'b0;

  always #2.5 clk = ~clk;

  pq_source_engine u_pq_source_engine (
    .clk         (clk),
    .rst_n       (rst_n),
    .irq_in      (irq_in),
    .reg_req     (reg_req),
    .reg_wr      (reg_wr),
    .reg_addr    (reg_addr),
    .rsp_valid   (rsp_valid),
    .rsp_data    (rsp_data),
    .notif_valid (notif_valid),
    .notif_ready (notif_ready),
    .notif_src   (notif_src)
  );

  function automatic logic [AW-1:0] trig_a(int s);
    return AW'(s << SH);
  endfunction

  function automatic logic [AW-1:0] mgmt_a(int s, int off);
    return AW'((s << SH) | (1 << (SH - 1)) | off);
  endfunction

  task automatic check(bit ok, string req, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic do_load(logic [AW-1:0] a, output logic [1:0] pq);
    @(negedge clk);
    reg_req = 1'b1; reg_wr = 1'b0; reg_addr = a;
    @(posedge clk);
    @(negedge clk);
    reg_req = 1'b0;
    check(rsp_valid === 1'b1, "R11 rsp_valid", rsp_valid, 1);
    check(rsp_data[63:2] === '0, "R11 upper bits", rsp_data[63:2], 0);
    pq = rsp_data[1:0];
  endtask

  task automatic do_store(logic [AW-1:0] a);
    @(negedge clk);
    reg_req = 1'b1; reg_wr = 1'b1; reg_addr = a;
    @(posedge clk);
    @(negedge clk);
    reg_req = 1'b0; reg_wr = 1'b0;
  endtask

  task automatic expect_state(int s, logic [1:0] exp, string req);
    logic [1:0] got;
    do_load(mgmt_a(s, 'h800), got);
    check(got === exp, req, got, exp);
  endtask

  task automatic expect_notif(int s, string req);
    for (int k = 0; k < 5 && !notif_valid; k++) @(negedge clk);
    check(notif_valid === 1'b1, req, notif_valid, 1);
    check(notif_src === SW'(s), req, notif_src, s);
    notif_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    notif_ready = 1'b0;
  endtask

  task automatic expect_quiet(string req);
    repeat (3) @(negedge clk);
    check(notif_valid === 1'b0, req, notif_valid, 0);
  endtask

  task automatic t_reset;
    check(notif_valid === 1'b0, "R1 notif after reset", notif_valid, 0);
    for (int s = 0; s < N; s++) expect_state(s, 2'b00, "R1 state after reset");
  endtask

  task automatic t_trigger_store;
    do_store(trig_a(2));
    expect_notif(2, "R2 idle trigger notifies");
    expect_state(2, 2'b10, "R2 idle->pending");
    do_store(trig_a(2));
    expect_state(2, 2'b11, "R2 pending->queued");
    do_store(trig_a(2));
    expect_state(2, 2'b11, "R2 queued stays");
    expect_quiet("R2 no extra notification");
  endtask

  task automatic t_set_pq;
    logic [1:0] got;
    do_load(mgmt_a(4, 'hD00), got);
    check(got === 2'b00, "R5 set01 returns old", got, 0);
    expect_state(4, 2'b01, "R5 set01 new state");
    do_store(trig_a(4));
    expect_state(4, 2'b01, "R2 off drops trigger");
    expect_quiet("R2 off no notification");
    do_load(mgmt_a(4, 'hF00), got);
    check(got === 2'b01, "R5 set11 returns old", got, 1);
    expect_state(4, 2'b11, "R5 set11 new state");
    do_load(mgmt_a(4, 'hC00), got);
    check(got === 2'b11, "R5 set00 returns old", got, 3);
    expect_state(4, 2'b00, "R5 set00 new state");
    do_load(mgmt_a(4, 'hE00), got);
    check(got === 2'b00, "R5 set10 returns old", got, 0);
    expect_state(4, 2'b10, "R5 set10 new state");
    expect_quiet("R5 set never notifies");
  endtask

  task automatic t_eoi;
    logic [1:0] got;
    do_load(mgmt_a(2, 'h000), got);
    check(got === 2'b11, "R3 eoi returns old", got, 3);
    expect_notif(2, "R3 eoi with Q renotifies");
    expect_state(2, 2'b10, "R3 eoi with Q to pending");
    do_store(mgmt_a(2, 'h400));
    check(rsp_valid === 1'b0, "R6 store eoi no response", rsp_valid, 0);
    expect_state(2, 2'b00, "R6 store eoi clears");
    expect_quiet("R6 store eoi without Q quiet");
  endtask

  task automatic t_layout;
    logic [1:0] got;
    do_store(mgmt_a(5, 'h800));
    expect_state(5, 2'b00, "R7 mgmt store ignored");
    expect_quiet("R7 mgmt store no notification");
    do_load(trig_a(4), got);
    check(got === 2'b10, "R4 trigger page load reads", got, 2);
    expect_state(4, 2'b10, "R4 read leaves state");
    expect_state(4, 2'b10, "R4 repeated read stable");
  endtask

  task automatic t_edge_line;
    logic [1:0] got;
    @(negedge clk); irq_in[0] = 1'b1;
    expect_notif(0, "R8 rising edge notifies");
    repeat (4) @(negedge clk);
    expect_state(0, 2'b10, "R8 held high no retrigger");
    irq_in[0] = 1'b0;
    @(negedge clk); irq_in[0] = 1'b1;
    @(negedge clk);
    expect_state(0, 2'b11, "R8 second edge queues");
    expect_quiet("R8 second edge quiet");
    do_load(mgmt_a(0, 'h000), got);
    check(got === 2'b11, "R3 edge eoi old", got, 3);
    expect_notif(0, "R3 edge eoi replay");
    irq_in[0] = 1'b0;
  endtask

  task automatic t_level_line;
    logic [1:0] got;
    @(negedge clk); irq_in[7] = 1'b1;
    expect_notif(7, "R9 level assert notifies");
    do_load(mgmt_a(7, 'h000), got);
    check(got === 2'b10, "R9 eoi old state", got, 2);
    expect_notif(7, "R9 eoi while asserted retriggers");
    expect_state(7, 2'b10, "R9 pending after retrigger");
    @(negedge clk); irq_in[7] = 1'b0;
    do_load(mgmt_a(7, 'h000), got);
    check(got === 2'b10, "R9 eoi old state low", got, 2);
    expect_quiet("R9 eoi deasserted quiet");
    expect_state(7, 2'b00, "R9 idle after eoi");
  endtask

  task automatic t_backpressure;
    do_store(mgmt_a(6, 'hC00) & '0 | trig_a(6));
    do_store(trig_a(3));
    do_store(trig_a(1));
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check(notif_valid === 1'b1 && notif_src === SW'(6), "R10 hold under stall",
            notif_src, 6);
    end
    expect_notif(6, "R10 first issued");
    expect_notif(1, "R10 lowest owed next");
    expect_notif(3, "R10 last owed kept");
    expect_quiet("R10 drained");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_trigger_store();
    t_set_pq();
    t_eoi();
    t_layout();
    t_edge_line();
    t_level_line();
    t_backpressure();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule